// File: doc/BRIEF.md
# Compare Event Routing and Latch

This block routes a digital compare event to the force, interrupt, conversion-start and sync outputs of one PWM channel. It handles `N_EVT` independent event lanes. For each lane, a source selector picks either the filtered or the raw comparator event. A one-cycle software force strobe is merged into the selected event. A path selector then sends either the merged event itself (asynchronous path) or a copy retimed to the time-base clock enable (synchronous path) to the force output.

The rising edge of the routed event drives three things. It sets a sticky flag when interrupts are enabled for that lane. It produces a one-cycle conversion-start pulse and a one-cycle sync pulse, each gated by its own enable. The flag stays set until a dedicated clear strobe arrives. If a new edge arrives in the same cycle as the clear, the set wins.

Top module: `cmp_evt_router`

## Requirements
- R1: With `src_filt[i]`=1 lane i uses `evt_filt[i]`; with `src_filt[i]`=0 it uses `evt_raw[i]`. The unselected input has no effect on `force_o[i]`.
- R2: A one-cycle `frc_stb[i]` pulse is ORed with the selected event. It raises `force_o[i]` and, like a real event, sets the flag and produces the gated pulses.
- R3: With `path_async[i]`=1, `force_o[i]` follows the merged event in the same cycle, with no register in the path.
- R4: With `path_async[i]`=0, `force_o[i]` is the merged event registered at a rising `clk` edge while `tb_en`=1. It holds its value while `tb_en`=0.
- R5: A rising edge of `force_o[i]` sets the lane's latch on the next clock edge, but only if `int_en[i]`=1 at that edge. `flag_o[i]` shows the latch. `irq_o[i]` = `flag_o[i]` AND `int_en[i]`.
- R6: A one-cycle `clr_stb[i]` clears the latch on the next edge. Otherwise the flag stays set, even after the event level falls.
- R7: If a latch-setting edge and `clr_stb[i]` arrive in the same cycle, the flag ends up set.
- R8: The latch responds to the rising edge only. An event level that stays high after a clear does not set the flag again.
- R9: `soc_o[i]` is a one-cycle pulse. It is asserted in the cycle after a rising edge of `force_o[i]` when `soc_en[i]`=1, and stays 0 when `soc_en[i]`=0.
- R10: `sync_o[i]` behaves the same way as `soc_o[i]`, gated by `sync_en[i]`.
- R11: While `rst`=1, and after it, the latch, `flag_o`, `irq_o`, `soc_o`, `sync_o` and the retimed event are all 0.
- R12: Lanes are independent. Activity on one lane changes no output of another lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_en | input | 1 | Time-base clock enable for the synchronous path |
| evt_raw | input | N_EVT | Unfiltered compare events |
| evt_filt | input | N_EVT | Filtered compare events |
| frc_stb | input | N_EVT | Software force strobes, one cycle |
| clr_stb | input | N_EVT | Flag clear strobes, one cycle |
| src_filt | input | N_EVT | 1 = filtered source, 0 = raw source |
| path_async | input | N_EVT | 1 = asynchronous path, 0 = time-base retimed path |
| int_en | input | N_EVT | Interrupt enable per lane |
| soc_en | input | N_EVT | Conversion-start enable per lane |
| sync_en | input | N_EVT | Sync enable per lane |
| force_o | output | N_EVT | Routed event to the force logic |
| flag_o | output | N_EVT | Sticky event flag |
| irq_o | output | N_EVT | Gated interrupt request |
| soc_o | output | N_EVT | Conversion-start pulse |
| sync_o | output | N_EVT | Sync pulse |

## Verification
The bench builds the block with the default `N_EVT` = 2. With two lanes, a stimulus applied only to lane 1 can be checked against an idle lane 0 whose flag is already clear, which exercises lane independence. Lane 0 runs through both paths, both sources, the force strobe, the enable gating and the simultaneous set/clear corner. `tb_en` is held low for stretches so that the hold behaviour of the retimed path is visible at `force_o`.

// File: rtl/cer_pkg.sv
package cer_pkg;
  typedef struct packed {
    logic src_filt;
    logic path_async;
    logic int_en;
    logic soc_en;
    logic sync_en;
  } evt_cfg_t;
endpackage

// File: rtl/cer_evt_path.sv
module cer_evt_path (
  input  logic clk,
  input  logic rst,
  input  logic tb_en,
  input  logic evt_raw,
  input  logic evt_filt,
  input  logic frc_stb,
  input  logic src_filt,
  input  logic path_async,
  output logic evt_o
);
  logic ev_sel;
  logic ev_mrg;
  logic ev_q;

  // source choice, then software force merged in
  assign ev_sel = src_filt ? evt_filt : evt_raw;
  assign ev_mrg = ev_sel | frc_stb;

  // retimed copy, advanced only on time-base enable
  always_ff @(posedge clk) begin
    if (rst)        ev_q <= 1'b0;
    else if (tb_en) ev_q <= ev_mrg;
  end

  assign evt_o = path_async ? ev_mrg : ev_q;

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !tb_en |=> $stable(ev_q));
  p_retime_r4: assert property (@(posedge clk) disable iff (rst)
    (tb_en && !path_async) |=> (evt_o == $past(ev_mrg)));
endmodule

// File: rtl/cer_edge_gate.sv
module cer_edge_gate (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  input  logic soc_en,
  input  logic sync_en,
  output logic rise_o,
  output logic soc_o,
  output logic sync_o
);
  logic prev_q;
  logic soc_q;
  logic sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      soc_q  <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      prev_q <= evt_i;
      soc_q  <= rise_o & soc_en;
      sync_q <= rise_o & sync_en;
    end
  end

  assign rise_o = evt_i & ~prev_q;
  assign soc_o  = soc_q;
  assign sync_o = sync_q;

  p_soc_single_r9: assert property (@(posedge clk) disable iff (rst)
    soc_o |=> !soc_o);
  p_soc_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !soc_en |=> !soc_o);
  p_sync_single_r10: assert property (@(posedge clk) disable iff (rst)
    sync_o |=> !sync_o);
  p_sync_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !sync_en |=> !sync_o);
endmodule

// File: rtl/cer_flag_latch.sv
module cer_flag_latch (
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  input  logic int_en,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_o
);
  logic latch_q;
  logic set_c;

  assign set_c = rise_i & int_en;

  // set has priority over clear
  always_ff @(posedge clk) begin
    if (rst)        latch_q <= 1'b0;
    else if (set_c) latch_q <= 1'b1;
    else if (clr_i) latch_q <= 1'b0;
  end

  assign flag_o = latch_q;
  assign irq_o  = latch_q & int_en;

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (rise_i && int_en) |=> flag_o);
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !(rise_i && int_en)) |=> !flag_o);
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o);
  p_no_set_r5: assert property (@(posedge clk) disable iff (rst)
    (!flag_o && !rise_i) |=> !flag_o);
endmodule

// File: rtl/cmp_evt_router.sv
module cmp_evt_router #(
  parameter int N_EVT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tb_en,
  input  logic [N_EVT-1:0] evt_raw,
  input  logic [N_EVT-1:0] evt_filt,
  input  logic [N_EVT-1:0] frc_stb,
  input  logic [N_EVT-1:0] clr_stb,
  input  logic [N_EVT-1:0] src_filt,
  input  logic [N_EVT-1:0] path_async,
  input  logic [N_EVT-1:0] int_en,
  input  logic [N_EVT-1:0] soc_en,
  input  logic [N_EVT-1:0] sync_en,
  output logic [N_EVT-1:0] force_o,
  output logic [N_EVT-1:0] flag_o,
  output logic [N_EVT-1:0] irq_o,
  output logic [N_EVT-1:0] soc_o,
  output logic [N_EVT-1:0] sync_o
);
  import cer_pkg::*;

  for (genvar g = 0; g < N_EVT; g++) begin : g_lane
    evt_cfg_t cfg;
    logic     evt_w;
    logic     rise_w;

    assign cfg = '{src_filt:   src_filt[g],
                   path_async: path_async[g],
                   int_en:     int_en[g],
                   soc_en:     soc_en[g],
                   sync_en:    sync_en[g]};

    cer_evt_path u_path (
      .clk        (clk),
      .rst        (rst),
      .tb_en      (tb_en),
      .evt_raw    (evt_raw[g]),
      .evt_filt   (evt_filt[g]),
      .frc_stb    (frc_stb[g]),
      .src_filt   (cfg.src_filt),
      .path_async (cfg.path_async),
      .evt_o      (evt_w)
    );

    cer_edge_gate u_edge (
      .clk     (clk),
      .rst     (rst),
      .evt_i   (evt_w),
      .soc_en  (cfg.soc_en),
      .sync_en (cfg.sync_en),
      .rise_o  (rise_w),
      .soc_o   (soc_o[g]),
      .sync_o  (sync_o[g])
    );

    cer_flag_latch u_latch (
      .clk    (clk),
      .rst    (rst),
      .rise_i (rise_w),
      .int_en (cfg.int_en),
      .clr_i  (clr_stb[g]),
      .flag_o (flag_o[g]),
      .irq_o  (irq_o[g])
    );

    assign force_o[g] = evt_w;
  end

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (flag_o == '0 && soc_o == '0 && sync_o == '0));
endmodule

// File: tb/tb_cmp_evt_router.sv
module tb_cmp_evt_router;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tb_en = 1'b0;
  logic [N-1:0] evt_raw = '0, evt_filt = '0, frc_stb = '0, clr_stb = '0;
  logic [N-1:0] src_filt = '0, path_async = '0, int_en = '0, soc_en = '0, sync_en = '0;
  logic [N-1:0] force_o, flag_o, irq_o, soc_o, sync_o;

  always #5 clk = ~clk;

  cmp_evt_router #(.N_EVT(N)) dut (
    .clk(clk), .rst(rst), .tb_en(tb_en),
    .evt_raw(evt_raw), .evt_filt(evt_filt), .frc_stb(frc_stb), .clr_stb(clr_stb),
    .src_filt(src_filt), .path_async(path_async), .int_en(int_en),
    .soc_en(soc_en), .sync_en(sync_en),
    .force_o(force_o), .flag_o(flag_o), .irq_o(irq_o), .soc_o(soc_o), .sync_o(sync_o)
  );

  typedef struct {
    int    kind;
    int    ch;
    bit    val;
    string req;
  } exp_t;

  exp_t q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  event smp;

  function automatic bit get_out(int kind, int ch);
    case (kind)
      0: return force_o[ch];
      1: return flag_o[ch];
      2: return irq_o[ch];
      3: return soc_o[ch];
      default: return sync_o[ch];
    endcase
  endfunction

  // monitor: pops expected items and compares against outputs
  initial forever begin
    @(smp);
    while (q.size() > 0) begin
      exp_t e;
      bit   got;
      e   = q.pop_front();
      got = get_out(e.kind, e.ch);
      n_run++;
      if (got !== e.val) begin
        n_fail++;
        $display("FAIL %s: output %0d lane %0d got %0b expected %0b", e.req, e.kind, e.ch, got, e.val);
      end
    end
  end

  task automatic expect_o(int kind, int ch, bit v, string req);
    exp_t e;
    e.kind = kind; e.ch = ch; e.val = v; e.req = req;
    q.push_back(e);
  endtask

  task automatic check_now();
    #1;
    -> smp;
    wait (q.size() == 0);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_lane(int ch);
    clr_stb[ch] = 1'b1;
    tick();
    clr_stb[ch] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    repeat (3) tick();
    for (int c = 0; c < N; c++) begin
      expect_o(1, c, 0, "R11"); expect_o(2, c, 0, "R11");
      expect_o(3, c, 0, "R11"); expect_o(4, c, 0, "R11");
    end
    check_now();
    rst = 1'b0;
    path_async = '1; int_en = '1; soc_en = '1; sync_en = '1;
    tick();

    // R1 raw source selected: filtered input ignored
    evt_filt[0] = 1'b1;
    expect_o(0, 0, 0, "R1"); check_now();
    // R3 async path: same-cycle response
    evt_raw[0] = 1'b1;
    expect_o(0, 0, 1, "R3"); check_now();
    tick();
    expect_o(1, 0, 1, "R5"); expect_o(2, 0, 1, "R5");
    expect_o(3, 0, 1, "R9"); expect_o(4, 0, 1, "R10");
    check_now();
    tick();
    expect_o(3, 0, 0, "R9"); expect_o(4, 0, 0, "R10"); expect_o(1, 0, 1, "R6");
    check_now();
    // R1 filtered source: raw input ignored
    src_filt[0] = 1'b1; evt_raw[0] = 1'b0;
    expect_o(0, 0, 1, "R1"); check_now();
    evt_filt[0] = 1'b0;
    expect_o(0, 0, 0, "R1"); check_now();
    tick();
    expect_o(1, 0, 1, "R6"); check_now();

    // R6 clear
    clear_lane(0);
    expect_o(1, 0, 0, "R6"); expect_o(2, 0, 0, "R6"); check_now();

    // R8 held level does not re-set after clear
    evt_filt[0] = 1'b1;
    tick();
    expect_o(1, 0, 1, "R8"); check_now();
    clear_lane(0);
    tick(); tick();
    expect_o(1, 0, 0, "R8"); expect_o(3, 0, 0, "R8"); check_now();
    evt_filt[0] = 1'b0;
    tick();

    // R7 set and clear together
    evt_filt[0] = 1'b1; clr_stb[0] = 1'b1;
    tick();
    clr_stb[0] = 1'b0;
    expect_o(1, 0, 1, "R7"); check_now();
    evt_filt[0] = 1'b0;
    clear_lane(0);

    // R2 software force
    frc_stb[0] = 1'b1;
    expect_o(0, 0, 1, "R2"); check_now();
    tick();
    frc_stb[0] = 1'b0;
    expect_o(1, 0, 1, "R2"); expect_o(3, 0, 1, "R2"); expect_o(0, 0, 0, "R2");
    check_now();
    tick();
    clear_lane(0);

    // R5/R9/R10 gating off
    int_en[0] = 1'b0; soc_en[0] = 1'b0; sync_en[0] = 1'b0;
    evt_filt[0] = 1'b1;
    tick();
    expect_o(1, 0, 0, "R5"); expect_o(2, 0, 0, "R5");
    expect_o(3, 0, 0, "R9"); expect_o(4, 0, 0, "R10");
    check_now();
    evt_filt[0] = 1'b0;
    tick();
    // R5 irq masked while flag stays; R9/R10 separate enables
    int_en[0] = 1'b1; soc_en[0] = 1'b1;
    evt_filt[0] = 1'b1;
    tick();
    expect_o(3, 0, 1, "R9"); expect_o(4, 0, 0, "R10"); expect_o(1, 0, 1, "R5");
    check_now();
    int_en[0] = 1'b0;
    expect_o(1, 0, 1, "R5"); expect_o(2, 0, 0, "R5"); check_now();
    int_en[0] = 1'b1; sync_en[0] = 1'b1; evt_filt[0] = 1'b0;
    tick();
    clear_lane(0);

    // R4 retimed path
    path_async[0] = 1'b0;
    evt_filt[0] = 1'b1;
    expect_o(0, 0, 0, "R4"); check_now();
    tick();
    expect_o(0, 0, 0, "R4"); expect_o(1, 0, 0, "R4"); check_now();
    tb_en = 1'b1;
    tick();
    expect_o(0, 0, 1, "R4"); check_now();
    tb_en = 1'b0; evt_filt[0] = 1'b0;
    tick();
    expect_o(1, 0, 1, "R4"); expect_o(4, 0, 1, "R10"); expect_o(0, 0, 1, "R4");
    check_now();
    tick();
    expect_o(0, 0, 1, "R4"); check_now();
    tb_en = 1'b1;
    tick();
    expect_o(0, 0, 0, "R4"); check_now();
    tb_en = 1'b0;
    clear_lane(0);

    // R12 lane independence
    evt_raw[1] = 1'b1;
    expect_o(0, 1, 1, "R12"); expect_o(0, 0, 0, "R12"); check_now();
    tick();
    expect_o(1, 1, 1, "R12"); expect_o(1, 0, 0, "R12");
    expect_o(3, 0, 0, "R12"); expect_o(3, 1, 1, "R12");
    check_now();
    evt_raw[1] = 1'b0;
    clear_lane(1);
    expect_o(1, 1, 0, "R12"); check_now();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule